// File: doc/BRIEF.md
# CRC and Checksum Engine

This block computes a running CRC or a 16-bit ones'-complement checksum over 32-bit words that a host writes through a small register interface. A control word selects one of four generator polynomials or the checksum mode. It also selects how the running value is started, how the four bytes of each input word are reordered, whether each input byte is bit-reflected, and whether the presented result is bit-reflected and/or inverted.

Each write to the data register advances the running context in the same clock edge. The context is visible, and writable, through the seed register. Software can therefore save a partial computation, run another one, and resume the first later by writing the saved value back. The post-processed result register applies output reflection and inversion to the context without changing it. Reads are combinational from the address.

Top module: `crc_cksum_engine`

## Requirements
- R1: After reset the control register, the context and the result all read as zero.
- R2: The control word is at offset 0x400 and reads back only its defined bits (mask 0x000073BF). The context is at 0x410 and the result is at 0x418. A read of the data offset 0x414 returns zero.
- R3: Control bits [3:0] select the operation. The codes 0, 1, 2 and 3 give polynomials 0x8005, 0x1021, 0x04C11DB7 and 0x1EDC6F41, each applied most-significant-bit first. A data write updates the context at the edge that accepts it.
- R4: A control write applies bits [14:13] at once. Code 10 clears the context. Code 11 sets all bits of the active width. Codes 00 and 01 keep the context, trimmed to the new width.
- R5: In 32-bit input mode, control bits [5:4] order the input bytes (B3 being bits 31:24) before they are consumed first to last. Code 00 gives B3,B2,B1,B0. Code 01 gives B2,B3,B0,B1. Code 10 gives B1,B0,B3,B2. Code 11 gives B0,B1,B2,B3.
- R6: Control bit 7 reflects the bit order inside every consumed input byte.
- R7: When control bit 12 is set, only bits [7:0] of a data write are consumed, and the upper 24 bits have no effect.
- R8: Control bit 8 reverses the result across the active width, and control bit 9 inverts it within that width. Neither bit changes the context.
- R9: For codes 0, 1 and 8 the width is 16, and bits [31:16] of the context and of the result read as zero.
- R10: Code 8 adds each 32-bit input as two 16-bit halves, or each byte zero-extended in 8-bit mode, into a 16-bit accumulator with end-around carry.
- R11: A write to the seed offset loads the context with the written value trimmed to the active width. This allows a saved context to be restored and the computation continued.
- R12: While the operation code is undefined (4 to 7, 9 to 15), data writes leave the context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
The assertions assume that reg_wr and reg_addr are known in every cycle after reset, and that the control word does not change in the same cycle as a seed write. This holds because a single port carries one write per cycle. The bench drives only single-cycle writes on the falling edge, with the strobe low between accesses. It reads only while no write is pending, so every assertion antecedent sees one well-defined access.

// File: rtl/ce_pkg.sv
package ce_pkg;

   localparam int WORD_W = 32;
   localparam int NPOLY  = 4;

   localparam logic [31:0] POLY_TAB [NPOLY] = '{32'h0000_8005, 32'h0000_1021,
                                                 32'h04C1_1DB7, 32'h1EDC_6F41};
   localparam int          POLY_W   [NPOLY] = '{16, 16, 32, 32};

   localparam logic [3:0]  KIND_CSUM = 4'd8;
   localparam logic [31:0] CTRL_MASK = 32'h0000_73BF;

   typedef struct packed {
      logic [1:0] start;
      logic       byte_mode;
      logic       out_inv;
      logic       out_rev;
      logic       in_rev;
      logic [1:0] lanes;
      logic [3:0] kind;
   } ce_ctrl_t;

   function automatic ce_ctrl_t ctrl_unpack(input logic [31:0] w);
      ce_ctrl_t c;
      c.kind      = w[3:0];
      c.lanes     = w[5:4];
      c.in_rev    = w[7];
      c.out_rev   = w[8];
      c.out_inv   = w[9];
      c.byte_mode = w[12];
      c.start     = w[14:13];
      return c;
   endfunction

   function automatic logic [31:0] ctrl_pack(input ce_ctrl_t c);
      logic [31:0] w;
      w        = '0;
      w[3:0]   = c.kind;
      w[5:4]   = c.lanes;
      w[7]     = c.in_rev;
      w[8]     = c.out_rev;
      w[9]     = c.out_inv;
      w[12]    = c.byte_mode;
      w[14:13] = c.start;
      return w;
   endfunction

   function automatic logic kind_narrow(input logic [3:0] k);
      return (k == 4'd0) || (k == 4'd1) || (k == KIND_CSUM);
   endfunction

   function automatic logic kind_valid(input logic [3:0] k);
      return (k[3:2] == 2'b00) || (k == KIND_CSUM);
   endfunction

   function automatic logic [31:0] width_mask(input logic [3:0] k);
      return kind_narrow(k) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/ce_lane_swizzle.sv
module ce_lane_swizzle #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] in_word,
   input  logic [1:0]        lanes,
   input  logic              in_rev,
   input  logic              byte_mode,
   output logic [WORD_W-1:0] stream
);
   localparam int NBYTE = WORD_W / 8;

   logic [WORD_W-1:0] ordered;
   logic [WORD_W-1:0] reflected;

   always_comb begin
      if (byte_mode) begin
         ordered = {in_word[7:0], {(WORD_W-8){1'b0}}};
      end else begin
         case (lanes)
            2'b01:   ordered = {in_word[23:16], in_word[31:24], in_word[7:0], in_word[15:8]};
            2'b10:   ordered = {in_word[15:0], in_word[31:16]};
            2'b11:   ordered = {in_word[7:0], in_word[15:8], in_word[23:16], in_word[31:24]};
            default: ordered = in_word;
         endcase
      end
   end

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign reflected[8*b+i] = ordered[8*b+7-i];
      end
   end

   assign stream = in_rev ? reflected : ordered;

endmodule

// File: rtl/ce_crc_lane.sv
module ce_crc_lane #(
   parameter int          WORD_W = 32,
   parameter int          W      = 32,
   parameter logic [31:0] POLY   = 32'h04C1_1DB7
) (
   input  logic [W-1:0]      ctx_in,
   input  logic [WORD_W-1:0] stream,
   input  logic              byte_mode,
   output logic [W-1:0]      ctx_out
);
   if (W != 16 && W != 32) begin : g_bad_w
      $error("ce_crc_lane: width must be 16 or 32");
   end

   always_comb begin
      logic [W-1:0] c;
      logic         fb;
      c = ctx_in;
      for (int i = 0; i < WORD_W; i++) begin
         if (!byte_mode || i < 8) begin
            fb = c[W-1] ^ stream[WORD_W-1-i];
            c  = {c[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : {W{1'b0}});
         end
      end
      ctx_out = c;
   end

endmodule

// File: rtl/ce_csum_fold.sv
module ce_csum_fold #(
   parameter int WORD_W = 32
) (
   input  logic [15:0]       acc_in,
   input  logic [WORD_W-1:0] stream,
   input  logic              byte_mode,
   output logic [15:0]       acc_out
);
   logic [15:0] hi_term;
   logic [15:0] lo_term;
   logic [17:0] raw;
   logic [16:0] fold1;
   logic [16:0] fold2;

   assign hi_term = byte_mode ? {8'h00, stream[WORD_W-1 -: 8]} : stream[WORD_W-1 -: 16];
   assign lo_term = byte_mode ? 16'h0000 : stream[15:0];
   assign raw     = {2'b00, acc_in} + {2'b00, hi_term} + {2'b00, lo_term};
   assign fold1   = {1'b0, raw[15:0]} + {15'd0, raw[17:16]};
   assign fold2   = {1'b0, fold1[15:0]} + {16'd0, fold1[16]};
   assign acc_out = fold2[15:0];

endmodule

// File: rtl/ce_post_proc.sv
module ce_post_proc #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] ctx,
   input  logic              narrow,
   input  logic              out_rev,
   input  logic              out_inv,
   output logic [WORD_W-1:0] result
);
   logic [WORD_W-1:0] rev_full;
   logic [15:0]       rev_half;
   logic [WORD_W-1:0] shaped;
   logic [WORD_W-1:0] wmask;

   for (genvar i = 0; i < WORD_W; i++) begin : g_rf
      assign rev_full[i] = ctx[WORD_W-1-i];
   end
   for (genvar i = 0; i < 16; i++) begin : g_rh
      assign rev_half[i] = ctx[15-i];
   end

   assign wmask  = narrow ? {{(WORD_W-16){1'b0}}, 16'hFFFF} : {WORD_W{1'b1}};

   always_comb begin
      if (!out_rev)     shaped = ctx;
      else if (narrow)  shaped = {{(WORD_W-16){1'b0}}, rev_half};
      else              shaped = rev_full;
   end

   assign result = (out_inv ? ~shaped : shaped) & wmask;

endmodule

// File: rtl/crc_cksum_engine.sv
module crc_cksum_engine #(
   parameter int              ADDR_W    = 12,
   parameter logic [11:0]     CTRL_OFS  = 12'h400,
   parameter logic [11:0]     SEED_OFS  = 12'h410,
   parameter logic [11:0]     DIN_OFS   = 12'h414,
   parameter logic [11:0]     RES_OFS   = 12'h418,
   parameter bit              HAS_CSUM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   import ce_pkg::*;

   localparam int WW = ce_pkg::WORD_W;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("crc_cksum_engine: ADDR_W too small for the offsets");
   end
   if (WW != 32) begin : g_bad_word
      $error("crc_cksum_engine: word width must be 32");
   end
   if (CTRL_OFS == SEED_OFS || SEED_OFS == DIN_OFS || DIN_OFS == RES_OFS
       || CTRL_OFS == RES_OFS) begin : g_bad_map
      $error("crc_cksum_engine: register offsets collide");
   end

   ce_ctrl_t      ctrl_q;
   logic [WW-1:0] ctx_q;
   logic [WW-1:0] ctx_d;
   logic [WW-1:0] stream;
   logic [WW-1:0] crc_next [NPOLY];
   logic [15:0]   csum_next;
   logic [WW-1:0] data_next;
   logic [WW-1:0] result;
   ce_ctrl_t      ctrl_new;
   logic          wr_ctrl, wr_seed, wr_din;

   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
   assign wr_seed  = reg_wr && (reg_addr == ADDR_W'(SEED_OFS));
   assign wr_din   = reg_wr && (reg_addr == ADDR_W'(DIN_OFS));
   assign ctrl_new = ctrl_unpack(reg_wdata);

   ce_lane_swizzle #(.WORD_W(WW)) u_swz (
      .in_word   (reg_wdata),
      .lanes     (ctrl_q.lanes),
      .in_rev    (ctrl_q.in_rev),
      .byte_mode (ctrl_q.byte_mode),
      .stream    (stream)
   );

   for (genvar g = 0; g < NPOLY; g++) begin : g_poly
      localparam int LW = POLY_W[g];
      logic [LW-1:0] lane_out;
      ce_crc_lane #(.WORD_W(WW), .W(LW), .POLY(POLY_TAB[g])) u_lane (
         .ctx_in    (ctx_q[LW-1:0]),
         .stream    (stream),
         .byte_mode (ctrl_q.byte_mode),
         .ctx_out   (lane_out)
      );
      assign crc_next[g] = WW'(lane_out);
   end

   if (HAS_CSUM) begin : g_csum
      ce_csum_fold #(.WORD_W(WW)) u_csum (
         .acc_in    (ctx_q[15:0]),
         .stream    (stream),
         .byte_mode (ctrl_q.byte_mode),
         .acc_out   (csum_next)
      );
   end else begin : g_nocsum
      assign csum_next = ctx_q[15:0];
   end

   always_comb begin
      if (ctrl_q.kind[3:2] == 2'b00)
         data_next = crc_next[ctrl_q.kind[1:0]];
      else if (HAS_CSUM && ctrl_q.kind == KIND_CSUM)
         data_next = {16'h0000, csum_next};
      else
         data_next = ctx_q;
   end

   always_comb begin
      ctx_d = ctx_q;
      if (wr_ctrl) begin
         case (ctrl_new.start)
            2'b10:   ctx_d = '0;
            2'b11:   ctx_d = width_mask(ctrl_new.kind);
            default: ctx_d = ctx_q & width_mask(ctrl_new.kind);
         endcase
      end else if (wr_seed) begin
         ctx_d = reg_wdata & width_mask(ctrl_q.kind);
      end else if (wr_din) begin
         ctx_d = data_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ctx_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_new;
         ctx_q <= ctx_d;
      end
   end

   ce_post_proc #(.WORD_W(WW)) u_post (
      .ctx     (ctx_q),
      .narrow  (kind_narrow(ctrl_q.kind)),
      .out_rev (ctrl_q.out_rev),
      .out_inv (ctrl_q.out_inv),
      .result  (result)
   );

   always_comb begin
      if (reg_addr == ADDR_W'(CTRL_OFS))      reg_rdata = ctrl_pack(ctrl_q);
      else if (reg_addr == ADDR_W'(SEED_OFS)) reg_rdata = ctx_q;
      else if (reg_addr == ADDR_W'(RES_OFS))  reg_rdata = result;
      else                                    reg_rdata = '0;
   end

   // R9
   narrow_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kind_narrow(ctrl_q.kind) |-> (ctx_q[31:16] == 16'h0000));

   // R12
   undef_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_din && !kind_valid(ctrl_q.kind)) |=> $stable(ctx_q));

   // R4
   init_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[14:13] == 2'b10) |=> (ctx_q == '0));

   // R4
   init_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[14:13] == 2'b11) |=> (ctx_q == width_mask(ctrl_q.kind)));

   // R11
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seed |=> (ctx_q == ($past(reg_wdata) & width_mask(ctrl_q.kind))));

endmodule

// File: tb/sim_crc_cksum_engine.sv
module sim_crc_cksum_engine;

   localparam logic [11:0] A_CTRL = 12'h400;
   localparam logic [11:0] A_SEED = 12'h410;
   localparam logic [11:0] A_DIN  = 12'h414;
   localparam logic [11:0] A_RES  = 12'h418;

   // table: control word, expected result after feeding "123456789" bytewise
   localparam int NV = 5;
   localparam logic [31:0] TV_CTRL [NV] = '{32'h5180, 32'h7001, 32'h7382, 32'h7383, 32'h7002};
   localparam logic [31:0] TV_EXP  [NV] = '{32'h0000BB3D, 32'h000029B1, 32'hCBF43926,
                                            32'hE3069283, 32'h0376E6E7};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   crc_cksum_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b,
                                            input int w, input logic [31:0] poly);
      logic [31:0] m;
      logic [31:0] top;
      m   = (w == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
      top = 32'h1 << (w - 1);
      c   = c ^ ({24'h0, b} << (w - 8));
      for (int k = 0; k < 8; k++) begin
         if ((c & top) != 0) c = ((c << 1) ^ poly) & m;
         else                c = (c << 1) & m;
      end
      return c;
   endfunction

   function automatic logic [15:0] rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int k = 0; k < 16; k++) r[k] = v[15-k];
      return r;
   endfunction

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v, exp, saved;
      logic [7:0]  order [4];

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(A_CTRL, v); check("R1 ctrl after reset", v, 32'h0);
      rd(A_SEED, v); check("R1 ctx after reset", v, 32'h0);
      rd(A_RES,  v); check("R1 result after reset", v, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R6 R7 R8 R9: table of standard check values
      for (int t = 0; t < NV; t++) begin
         wr(A_CTRL, TV_CTRL[t]);
         for (int k = 0; k < 9; k++) wr(A_DIN, 32'h31 + k);
         rd(A_RES, v);
         check($sformatf("R3 table vector %0d", t), v, TV_EXP[t]);
      end

      // R2 readback mask and data offset
      wr(A_CTRL, 32'hFFFF_FFF3);
      rd(A_CTRL, v); check("R2 ctrl readback mask", v, 32'h0000_73B3);
      rd(A_DIN, v);  check("R2 data offset reads zero", v, 32'h0);

      // R5 R6 R7: word mode, full reverse lanes, then byte mode with junk upper bits
      wr(A_CTRL, 32'h63B2);
      wr(A_DIN, 32'h34333231);
      wr(A_DIN, 32'h38373635);
      wr(A_CTRL, 32'h13B2);
      wr(A_DIN, 32'hABCDEF39);
      rd(A_RES, v); check("R7 word then byte mode crc32", v, 32'hCBF43926);

      // R5 each lane order
      for (int e = 0; e < 4; e++) begin
         case (e)
            0: order = '{8'h11, 8'h22, 8'h33, 8'h44};
            1: order = '{8'h22, 8'h11, 8'h44, 8'h33};
            2: order = '{8'h33, 8'h44, 8'h11, 8'h22};
            default: order = '{8'h44, 8'h33, 8'h22, 8'h11};
         endcase
         wr(A_CTRL, 32'h4002 | (e << 4));
         wr(A_DIN, 32'h11223344);
         exp = 32'h0;
         for (int k = 0; k < 4; k++) exp = ref_byte(exp, order[k], 32, 32'h04C11DB7);
         rd(A_SEED, v);
         check($sformatf("R5 lane order %0d", e), v, exp);
      end

      // R10 checksum
      wr(A_CTRL, 32'h4008);
      wr(A_DIN, 32'h45000073);
      wr(A_DIN, 32'h00004000);
      rd(A_SEED, v); check("R10 checksum sum", v, 32'h00008573);
      wr(A_CTRL, 32'h0208);
      rd(A_RES, v); check("R10 checksum inverted", v, 32'h00007A8C);
      wr(A_CTRL, 32'h6008);
      wr(A_DIN, 32'h00010000);
      rd(A_SEED, v); check("R10 end-around carry", v, 32'h00000001);

      // R9 R8 R11 narrowing, output reverse
      wr(A_CTRL, 32'h0002);
      wr(A_SEED, 32'h12345678);
      rd(A_SEED, v); check("R11 seed load 32-bit", v, 32'h12345678);
      wr(A_CTRL, 32'h0101);
      rd(A_SEED, v); check("R9 ctx trimmed to 16 bits", v, 32'h00005678);
      rd(A_RES, v);  check("R8 16-bit output reverse", v, {16'h0, rev16(16'h5678)});
      wr(A_CTRL, 32'h0301);
      rd(A_RES, v);  check("R8 reverse and invert", v, {16'h0, ~rev16(16'h5678)});
      rd(A_SEED, v); check("R8 ctx unaffected", v, 32'h00005678);
      wr(A_SEED, 32'hFFFF1234);
      rd(A_SEED, v); check("R9 seed write trimmed", v, 32'h00001234);

      // R4 init codes
      wr(A_CTRL, 32'h4001);
      rd(A_SEED, v); check("R4 init zeros", v, 32'h0);
      wr(A_CTRL, 32'h6001);
      rd(A_SEED, v); check("R4 init ones narrow", v, 32'h0000FFFF);
      wr(A_CTRL, 32'h6003);
      rd(A_SEED, v); check("R4 init ones wide", v, 32'hFFFFFFFF);

      // R12 undefined kind ignores data
      wr(A_CTRL, 32'h0004);
      wr(A_SEED, 32'hCAFEBABE);
      wr(A_DIN, 32'h12345678);
      rd(A_SEED, v); check("R12 undefined kind holds ctx", v, 32'hCAFEBABE);

      // R11 save and resume
      wr(A_CTRL, 32'h6002);
      wr(A_DIN, 32'h11111111);
      rd(A_SEED, saved);
      wr(A_CTRL, 32'h4001);
      wr(A_DIN, 32'h00000055);
      wr(A_CTRL, 32'h0002);
      wr(A_SEED, saved);
      wr(A_DIN, 32'h22222222);
      exp = 32'hFFFFFFFF;
      for (int k = 0; k < 4; k++) exp = ref_byte(exp, 8'h11, 32, 32'h04C11DB7);
      for (int k = 0; k < 4; k++) exp = ref_byte(exp, 8'h22, 32, 32'h04C11DB7);
      rd(A_SEED, v); check("R11 save and resume", v, exp);

      // R1 reset again mid-run
      rst_n = 1'b0;
      #1;
      rd(A_SEED, v); check("R1 ctx cleared by reset", v, 32'h0);
      rst_n = 1'b1;

      finish_run();
   end

endmodule